// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style controller core. In every cycle it combines the working-register operand with a second operand, which is either a file-register value or an instruction literal. It produces an 8-bit result and a destination strobe that says whether the result goes back to the file register or to the working register. The selected operation decides which of the carry, digit-carry and zero flags it may change.

The flags are held in registers inside the block. They change only on a rising clock edge with the execute strobe high, and only the flags the operation owns are written. The rotate operations use the registered carry as their incoming carry. The result and the destination strobe are combinational. A flag update can be seen after the next rising edge.

Top module: `acc_alu`

## Requirements
- R1: Operation codes on `op_i`: 0 store-W, 1 add, 2 subtract, 3 AND, 4 OR, 5 XOR, 6 complement, 7 increment, 8 decrement, 9 clear, 10 move, 11 rotate left, 12 rotate right, 13 nibble swap, 14 bit set, 15 bit clear, 16 load-literal. Add returns (F + W) mod 256. It sets C on a carry out of bit 7, sets DC on a carry out of bit 3 into bit 4, and sets Z when the result is zero.
- R2: Subtract returns (F − W) mod 256. C is 1 when F ≥ W and 0 when a borrow occurs. DC is 1 when F[3:0] ≥ W[3:0]. Z is set for a zero result.
- R3: AND, OR, XOR, complement (~F), clear (0) and move (F) write only Z. C and DC keep their values.
- R4: Increment and decrement wrap modulo 256 and write only Z. Incrementing 0xFF gives 0x00 with Z = 1. Decrementing 0x01 gives 0x00 with Z = 1.
- R5: Rotate left returns {F[6:0], C} and loads C from F[7]. Rotate right returns {C, F[7:1]} and loads C from F[0]. DC and Z are unchanged.
- R6: Nibble swap returns {F[3:0], F[7:4]}. Bit set returns F with bit `bit_sel_i` forced to 1. Bit clear returns F with that bit forced to 0. None of the three changes a flag.
- R7: Store-W returns W with `wr_file_o` = 1. Load-literal returns F with `wr_file_o` = 0. Neither changes a flag.
- R8: For every other code, `wr_file_o` follows `dest_f_i`: 1 selects the file register and 0 selects W.
- R9: Flags change only on a rising edge with `exec_i` = 1. With `exec_i` = 0 all three flags hold.
- R10: While `rst_n` is low, C, DC and Z are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Commit flag updates on this edge |
| op_i | input | 5 | Operation code |
| w_i | input | 8 | Working-register operand |
| f_i | input | 8 | File-register or literal operand |
| bit_sel_i | input | 3 | Bit index for bit set and bit clear |
| dest_f_i | input | 1 | Destination select, 1 = file register |
| result_o | output | 8 | Operation result |
| wr_file_o | output | 1 | Result targets the file register |
| c_o | output | 1 | Carry flag (inverse of borrow on subtract) |
| dc_o | output | 1 | Digit-carry flag |
| z_o | output | 1 | Zero flag |

## Verification
The result and the destination strobe are valid in the same cycle as the operands, because no register lies on that path. The bench drives inputs just after a falling edge and samples these outputs a quarter period later. The flags pass through one register, so the bench advances its own flag model on the rising edge and reads `c_o`, `dc_o` and `z_o` one time unit after that edge. Rotates depend on the carry that is already stored, so the bench's carry prediction is taken from its own model, which has tracked every earlier committed operation. Random operands are mixed with directed wrap, borrow and held-flag cases.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW  = 8,
  parameter int OPW = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   exec_i,
  input  logic [OPW-1:0]         op_i,
  input  logic [DW-1:0]          w_i,
  input  logic [DW-1:0]          f_i,
  input  logic [$clog2(DW)-1:0]  bit_sel_i,
  input  logic                   dest_f_i,
  output logic [DW-1:0]          result_o,
  output logic                   wr_file_o,
  output logic                   c_o,
  output logic                   dc_o,
  output logic                   z_o
);
  localparam int HALF = DW / 2;
  localparam logic [OPW-1:0] OP_STW = 0, OP_ADD = 1, OP_SUB = 2, OP_AND = 3,
    OP_IOR = 4, OP_XOR = 5, OP_COM = 6, OP_INC = 7, OP_DEC = 8, OP_CLR = 9,
    OP_MOV = 10, OP_RLC = 11, OP_RRC = 12, OP_SWP = 13, OP_BST = 14,
    OP_BCL = 15, OP_LDW = 16;

  logic [DW:0]     add_w, sub_w;
  logic [HALF:0]   add_n, sub_n;
  logic [DW-1:0]   mask, res;
  logic            nc, ndc, uc, udc, uz;

  assign add_w = {1'b0, f_i} + {1'b0, w_i};
  assign sub_w = {1'b0, f_i} + {1'b0, ~w_i} + {{DW{1'b0}}, 1'b1};
  assign add_n = {1'b0, f_i[HALF-1:0]} + {1'b0, w_i[HALF-1:0]};
  assign sub_n = {1'b0, f_i[HALF-1:0]} + {1'b0, ~w_i[HALF-1:0]} + {{HALF{1'b0}}, 1'b1};
  assign mask  = {{(DW-1){1'b0}}, 1'b1} << bit_sel_i;

  always_comb begin
    res = '0; nc = c_o; ndc = dc_o; uc = 1'b0; udc = 1'b0; uz = 1'b0;
    case (op_i)
      OP_STW: res = w_i;
      OP_ADD: begin res = add_w[DW-1:0]; nc = add_w[DW]; ndc = add_n[HALF]; uc = 1'b1; udc = 1'b1; uz = 1'b1; end
      OP_SUB: begin res = sub_w[DW-1:0]; nc = sub_w[DW]; ndc = sub_n[HALF]; uc = 1'b1; udc = 1'b1; uz = 1'b1; end
      OP_AND: begin res = f_i & w_i; uz = 1'b1; end
      OP_IOR: begin res = f_i | w_i; uz = 1'b1; end
      OP_XOR: begin res = f_i ^ w_i; uz = 1'b1; end
      OP_COM: begin res = ~f_i; uz = 1'b1; end
      OP_INC: begin res = f_i + 1'b1; uz = 1'b1; end
      OP_DEC: begin res = f_i - 1'b1; uz = 1'b1; end
      OP_CLR: begin res = '0; uz = 1'b1; end
      OP_MOV: begin res = f_i; uz = 1'b1; end
      OP_RLC: begin res = {f_i[DW-2:0], c_o}; nc = f_i[DW-1]; uc = 1'b1; end
      OP_RRC: begin res = {c_o, f_i[DW-1:1]}; nc = f_i[0]; uc = 1'b1; end
      OP_SWP: res = {f_i[HALF-1:0], f_i[DW-1:HALF]};
      OP_BST: res = f_i | mask;
      OP_BCL: res = f_i & ~mask;
      OP_LDW: res = f_i;
      default: res = '0;
    endcase
  end

  assign result_o  = res;
  assign wr_file_o = (op_i == OP_STW) ? 1'b1 : (op_i == OP_LDW) ? 1'b0 : dest_f_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_o <= 1'b0; dc_o <= 1'b0; z_o <= 1'b0;
    end else if (exec_i) begin
      if (uc)  c_o  <= nc;
      if (udc) dc_o <= ndc;
      if (uz)  z_o  <= (res == '0);
    end
  end
endmodule

module acc_alu_chk #(
  parameter int DW  = 8,
  parameter int OPW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           exec_i,
  input logic [OPW-1:0] op_i,
  input logic [DW-1:0]  f_i,
  input logic [DW-1:0]  result_o,
  input logic           wr_file_o,
  input logic           c_o,
  input logic           dc_o,
  input logic           z_o
);
  logic zonly, none;
  assign zonly = (op_i >= OPW'(3)) && (op_i <= OPW'(10));
  assign none  = (op_i == OPW'(0)) || (op_i == OPW'(13)) || (op_i == OPW'(14)) ||
                 (op_i == OPW'(15)) || (op_i == OPW'(16));

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> ($stable(c_o) && $stable(dc_o) && $stable(z_o))); // R9
  AST_ZONLY_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && zonly) |=> ($stable(c_o) && $stable(dc_o))); // R3
  AST_ZONLY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && zonly) |=> (z_o == ($past(result_o) == '0))); // R4
  AST_NOFLAG_OPS: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && none) |=> ($stable(c_o) && $stable(dc_o) && $stable(z_o))); // R6
  AST_RLC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_i && op_i == OPW'(11)) |=> (c_o == $past(f_i[DW-1]) && $stable(z_o))); // R5
  AST_STW_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OPW'(0)) |-> wr_file_o); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (!c_o && !dc_o && !z_o)); // R10
endmodule

bind acc_alu acc_alu_chk #(.DW(DW), .OPW(OPW)) chk_i (.*);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
  localparam int P = 10;
  logic clk = 0, rst_n = 0, exec_i = 0, dest_f_i = 0;
  logic [4:0] op_i = 0;
  logic [7:0] w_i = 0, f_i = 0;
  logic [2:0] bit_sel_i = 0;
  logic [7:0] result_o;
  logic wr_file_o, c_o, dc_o, z_o;
  int nvec = 0, nbad = 0;
  bit mc = 0, mdc = 0, mz = 0;

  always #(P/2) clk = ~clk;

  acc_alu dut_i (.clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i), .w_i(w_i),
    .f_i(f_i), .bit_sel_i(bit_sel_i), .dest_f_i(dest_f_i), .result_o(result_o),
    .wr_file_o(wr_file_o), .c_o(c_o), .dc_o(dc_o), .z_o(z_o));

  function automatic string tag(input int op);
    case (op)
      1: return "R1"; 2: return "R2"; 7, 8: return "R4";
      11, 12: return "R5"; 13, 14, 15: return "R6"; 0, 16: return "R7";
      3, 4, 5, 6, 9, 10: return "R3"; default: return "R8";
    endcase
  endfunction

  task automatic apply(input int op, input int w, input int f, input int b,
                       input bit d, input bit ex);
    int r, s; bit ec, edc, uc, udc, uz, ewf;
    @(negedge clk);
    op_i = op[4:0]; w_i = w[7:0]; f_i = f[7:0]; bit_sel_i = b[2:0];
    dest_f_i = d; exec_i = ex;
    #(P/4);
    ec = mc; edc = mdc; uc = 0; udc = 0; uz = 0; ewf = d;
    case (op)
      0: begin r = w; ewf = 1; end
      1: begin s = f + w; r = s % 256; ec = s > 255; edc = (f % 16 + w % 16) > 15; uc = 1; udc = 1; uz = 1; end
      2: begin r = (f - w + 256) % 256; ec = f >= w; edc = (f % 16) >= (w % 16); uc = 1; udc = 1; uz = 1; end
      3: begin r = f & w; uz = 1; end
      4: begin r = f | w; uz = 1; end
      5: begin r = f ^ w; uz = 1; end
      6: begin r = 255 - f; uz = 1; end
      7: begin r = (f + 1) % 256; uz = 1; end
      8: begin r = (f + 255) % 256; uz = 1; end
      9: begin r = 0; uz = 1; end
      10: begin r = f; uz = 1; end
      11: begin r = (f * 2) % 256 + (mc ? 1 : 0); ec = f >= 128; uc = 1; end
      12: begin r = f / 2 + (mc ? 128 : 0); ec = (f % 2) == 1; uc = 1; end
      13: r = (f % 16) * 16 + f / 16;
      14: r = f | (1 << b);
      15: r = f & (255 - (1 << b));
      16: begin r = f; ewf = 0; end
      default: r = 0;
    endcase
    nvec++;
    if (result_o !== r[7:0] || wr_file_o !== ewf) begin
      nbad++;
      $display("FAIL %s op=%0d result/dest %h/%b expected %h/%b", tag(op), op,
               result_o, wr_file_o, r[7:0], ewf);
    end
    @(posedge clk);
    if (ex) begin
      if (uc) mc = ec;
      if (udc) mdc = edc;
      if (uz) mz = (r == 0);
    end
    #1;
    if ({c_o, dc_o, z_o} !== {mc, mdc, mz}) begin
      nbad++;
      $display("FAIL %s op=%0d ex=%0b flags C/DC/Z %b%b%b expected %b%b%b", ex ? tag(op) : "R9",
               op, ex, c_o, dc_o, z_o, mc, mdc, mz);
    end
  endtask

  initial begin
    #(P * 200000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    nvec++;
    if ({c_o, dc_o, z_o} !== 3'b000) begin
      nbad++; $display("FAIL R10 flags %b%b%b expected 000", c_o, dc_o, z_o);
    end
    @(negedge clk); rst_n = 1;
    apply(1, 'h7C, 'h0F, 0, 0, 1);   // R1 nibble carry, no byte carry
    apply(1, 'hFF, 'h01, 0, 1, 1);   // R1 wrap to zero: C and Z set
    apply(1, 'h01, 'h01, 0, 0, 0);   // R9 flags hold with exec low
    apply(2, 'h41, 'h30, 0, 0, 1);   // R2 borrow
    apply(2, 'hAC, 'hAC, 0, 1, 1);   // R2 equal operands
    apply(2, 'h21, 'h69, 0, 0, 1);   // R2 positive
    apply(7, 0, 'hFF, 0, 1, 1);      // R4
    apply(8, 0, 'h01, 0, 0, 1);      // R4
    apply(3, 'h0F, 'hF0, 0, 0, 1);   // R3 zero via AND
    apply(11, 0, 'h9A, 0, 1, 1);     // R5
    apply(12, 0, 'h9A, 0, 1, 1);     // R5
    apply(13, 0, 'h6C, 0, 0, 1);     // R6
    apply(14, 0, 'h00, 7, 1, 1);     // R6
    apply(15, 0, 'hFF, 0, 1, 1);     // R6
    apply(0, 'hAA, 'hCC, 0, 0, 1);   // R7
    apply(16, 'hAA, 'h00, 0, 1, 1);  // R7
    for (int i = 0; i < 3000; i++)
      apply($urandom_range(16), $urandom_range(255), $urandom_range(255),
            $urandom_range(7), 1'($urandom_range(1)), $urandom_range(7) != 0);
    @(negedge clk); rst_n = 0; #1;
    nvec++;
    if ({c_o, dc_o, z_o} !== 3'b000) begin
      nbad++; $display("FAIL R10 flags after reset %b%b%b expected 000", c_o, dc_o, z_o);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule